// File: doc/BRIEF.md
# Receiver Status Flag Register

This block is the receiver-side status and interrupt flag register of a CAN controller. It holds four event flags in one 8-bit word: wake-up, status change, overrun and receive-buffer-full. Alongside them it shows two 2-bit fields, the receiver and transmitter status levels, which other logic inside the controller drives. The CPU reads the word, and it clears event flags by writing ones. A companion 8-bit enable register selects which flags may raise the interrupt request.

A flag will not clear while its cause is still present. A set event in the same cycle as a CPU clear therefore leaves the flag at 1. The status-change flag sets whenever either status field takes a new value.

An initialization handshake (request and acknowledge) controls the flags. While both are high, the flags are forced to zero and the status fields keep working. The flag register accepts CPU writes only when both handshake signals are low.

Top module: `rxflag_reg`

## Requirements
- R1: After reset, both `flag_rdata` and `enable_rdata` read 0x00 and `irq` is 0. A reset in the middle of operation clears the status view too.
- R2: `wake_evt`, `ovr_evt` or `rxfull_evt` high in a cycle outside initialization mode sets its flag at that clock edge. The flags sit at bit 7 (wake-up), bit 1 (overrun) and bit 0 (receive full) of `flag_rdata`.
- R3: The status-change flag, bit 6, sets at the clock edge where `rx_stat` or `tx_stat` differs from the value last captured. After reset the captured value is 00/00.
- R4: `flag_rdata[5:4]` shows `rx_stat` and `flag_rdata[3:2]` shows `tx_stat`, each captured at the clock edge. CPU writes to these bits have no effect.
- R5: A flag-register write with a 1 at a flag's bit position clears that flag at the clock edge. A 0 at that position leaves the flag unchanged.
- R6: A clear does not take effect while the flag's cause is active in the same cycle. An event input high, or a status difference, keeps the flag at 1.
- R7: While `init_req` and `init_ack` are both 1, the four flags read 0 from the next edge on and cannot set. The status fields keep following their inputs, and no status-change flag is raised for changes made during this time.
- R8: Flag-register writes are ignored unless `init_req` and `init_ack` are both 0. In those blocked cycles, if only one of them is 1, events can still set flags.
- R9: A write with `cpu_wr_en` loads enable bits 7, 6, 1 and 0 from `cpu_wdata` regardless of initialization state. Bits 5:2 of `enable_rdata` always read 0.
- R10: `irq` is 1 exactly when some flag bit and the same bit of the enable register are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_evt | input | 1 | Wake-up event/cause |
| ovr_evt | input | 1 | Receive overrun event/cause |
| rxfull_evt | input | 1 | Receive buffer full event/cause |
| rx_stat | input | 2 | Receiver status level from controller logic |
| tx_stat | input | 2 | Transmitter status level from controller logic |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| cpu_wr_flag | input | 1 | CPU write strobe for the flag register |
| cpu_wr_en | input | 1 | CPU write strobe for the enable register |
| cpu_wdata | input | 8 | CPU write data |
| flag_rdata | output | 8 | Flag register read value |
| enable_rdata | output | 8 | Enable register read value |
| irq | output | 1 | Interrupt request |

## Verification
The bench clears a flag in the same cycle its event is asserted. A design that lets the clear win would drop a pending event without reporting it. It writes all ones over the status fields; a design that lets the CPU write them would corrupt the status view. It changes a status level during initialization mode and then leaves the mode. A design that failed to track changes during that time would raise a stale status-change flag. It also tries writes and events with only one handshake signal high, which catches designs that treat the write gate and the hold-in-reset condition as the same thing. A final reset while a status level is nonzero checks that the status-change flag fires once the tracker restarts from zero.

// File: rtl/rxflag_pkg.sv
// Package: shared bit positions and helpers for the receiver flag register.
// Assumes an 8-bit register with 2-bit receiver and transmitter status fields.
package rxflag_pkg;
    localparam int REG_W    = 8;
    localparam int STAT_W   = 2;
    localparam int NUM_EVT  = 4;
    // Bit positions that software decodes
    localparam int POS_WAKE = 7;
    localparam int POS_STCH = 6;
    localparam int POS_RS   = 4;
    localparam int POS_TS   = 2;
    localparam int POS_OVR  = 1;
    localparam int POS_RXF  = 0;
    localparam logic [REG_W-1:0] EVT_MASK = 8'hC3;

    // Event index order used inside the block
    typedef enum int {
        EV_RXF  = 0,
        EV_OVR  = 1,
        EV_STCH = 2,
        EV_WAKE = 3
    } evt_idx_e;

    // Map an event index to its register bit position
    function automatic int evt_pos(int idx);
        case (idx)
            EV_RXF:  return POS_RXF;
            EV_OVR:  return POS_OVR;
            EV_STCH: return POS_STCH;
            default: return POS_WAKE;
        endcase
    endfunction
endpackage

// File: rtl/rxflag_event_cell.sv
// Module: one write-one-to-clear event flag.
// Assumes set_evt is the live cause; a set overrides a clear in the same
// cycle, and hold_zero (initialization mode) overrides both.
module rxflag_event_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_zero,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_q
);
    // Flag state: reset/hold first, then set, then clear
    always_ff @(posedge clk) begin
        if (!rst_n || hold_zero) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxflag_status_track.sv
// Module: captures receiver/transmitter status levels and reports a change.
// Assumes the levels are synchronous to clk; capture continues in all modes.
module rxflag_status_track #(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] rx_stat,
    input  logic [STAT_W-1:0] tx_stat,
    output logic [STAT_W-1:0] rx_q,
    output logic [STAT_W-1:0] tx_q,
    output logic              changed
);
    // Capture both levels every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
            tx_q <= '0;
        end else begin
            rx_q <= rx_stat;
            tx_q <= tx_stat;
        end
    end

    // A difference from the captured value marks a status change
    always_comb begin
        changed = (rx_stat != rx_q) || (tx_stat != tx_q);
    end
endmodule

// File: rtl/rxflag_irq_ctl.sv
// Module: interrupt-enable register and interrupt request combiner.
// Assumes only the event flag positions carry enables; others read zero.
module rxflag_irq_ctl #(
    parameter int                 REG_W = 8,
    parameter logic [REG_W-1:0]   MASK  = 8'hC3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] flags,
    output logic [REG_W-1:0] en_q,
    output logic             irq
);
    // Enable register, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wdata & MASK;
        end
    end

    // Request when any enabled flag is set
    always_comb begin
        irq = |(flags & en_q);
    end
endmodule

// File: rtl/rxflag_reg.sv
// Module: receiver status flag register top.
// Assumes CPU strobes and event inputs are synchronous to clk; flags are
// write-one-to-clear and gated by the initialization handshake.
module rxflag_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_evt,
    input  logic       ovr_evt,
    input  logic       rxfull_evt,
    input  logic [1:0] rx_stat,
    input  logic [1:0] tx_stat,
    input  logic       init_req,
    input  logic       init_ack,
    input  logic       cpu_wr_flag,
    input  logic       cpu_wr_en,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] flag_rdata,
    output logic [7:0] enable_rdata,
    output logic       irq
);
    import rxflag_pkg::*;

    logic                init_active;
    logic                wr_open;
    logic                stat_changed;
    logic [STAT_W-1:0]   rx_view;
    logic [STAT_W-1:0]   tx_view;
    logic [NUM_EVT-1:0]  evt_set;
    logic [NUM_EVT-1:0]  evt_flag;

    // Handshake decode: hold in reset versus write permission
    always_comb begin
        init_active = init_req && init_ack;
        wr_open     = !init_req && !init_ack;
    end

    // Event causes in internal index order
    always_comb begin
        evt_set          = '0;
        evt_set[EV_RXF]  = rxfull_evt;
        evt_set[EV_OVR]  = ovr_evt;
        evt_set[EV_STCH] = stat_changed;
        evt_set[EV_WAKE] = wake_evt;
    end

    rxflag_status_track #(.STAT_W(STAT_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_stat (rx_stat),
        .tx_stat (tx_stat),
        .rx_q    (rx_view),
        .tx_q    (tx_view),
        .changed (stat_changed)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        logic clr_bit;
        // Clear request for this flag from a permitted CPU write
        always_comb begin
            clr_bit = cpu_wr_flag && wr_open && cpu_wdata[evt_pos(g)];
        end
        rxflag_event_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_zero (init_active),
            .set_evt   (evt_set[g]),
            .clr_req   (clr_bit),
            .flag_q    (evt_flag[g])
        );
    end

    // Assemble the software-visible word
    always_comb begin
        flag_rdata                      = '0;
        flag_rdata[POS_WAKE]            = evt_flag[EV_WAKE];
        flag_rdata[POS_STCH]            = evt_flag[EV_STCH];
        flag_rdata[POS_RS+STAT_W-1:POS_RS] = rx_view;
        flag_rdata[POS_TS+STAT_W-1:POS_TS] = tx_view;
        flag_rdata[POS_OVR]             = evt_flag[EV_OVR];
        flag_rdata[POS_RXF]             = evt_flag[EV_RXF];
    end

    rxflag_irq_ctl #(.REG_W(REG_W), .MASK(EVT_MASK)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr_en),
        .wdata (cpu_wdata),
        .flags (flag_rdata),
        .en_q  (enable_rdata),
        .irq   (irq)
    );
endmodule

// File: rtl/rxflag_reg_chk.sv
// Module: assertion checker bound to rxflag_reg.
// Assumes the port names of the top; uses a one-cycle history guard.
module rxflag_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_evt,
    input logic       ovr_evt,
    input logic       rxfull_evt,
    input logic [1:0] rx_stat,
    input logic [1:0] tx_stat,
    input logic       init_req,
    input logic       init_ack,
    input logic       cpu_wr_flag,
    input logic       cpu_wr_en,
    input logic [7:0] cpu_wdata,
    input logic [7:0] flag_rdata,
    input logic [7:0] enable_rdata,
    input logic       irq
);
    logic hist_ok;

    // Marks that the previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    assert_init_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> ((flag_rdata & 8'hC3) == 8'h00));

    assert_event_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !(init_req && init_ack)) |=> flag_rdata[7]);

    assert_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_flag && !cpu_wdata[1] && flag_rdata[1] && !(init_req && init_ack))
        |=> flag_rdata[1]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rxfull_evt && cpu_wr_flag && cpu_wdata[0] && !(init_req && init_ack))
        |=> flag_rdata[0]);

    assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_flag && (init_req != init_ack) && flag_rdata[7]) |=> flag_rdata[7]);

    assert_status_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (flag_rdata[5:4] == $past(rx_stat) && flag_rdata[3:2] == $past(tx_stat)));

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_rdata & enable_rdata) != 8'h00));

    assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_en |=> (enable_rdata == ($past(cpu_wdata) & 8'hC3)));
endmodule

bind rxflag_reg rxflag_reg_chk u_chk (.*);

// File: tb/test_rxflag_reg.sv
// Bench: vector table walked by one loop, then directed reset/corner tests.
module test_rxflag_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wake_evt, ovr_evt, rxfull_evt;
    logic [1:0] rx_stat, tx_stat;
    logic       init_req, init_ack;
    logic       cpu_wr_flag, cpu_wr_en;
    logic [7:0] cpu_wdata;
    logic [7:0] flag_rdata, enable_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rxflag_reg i_rxflag_reg (.*);

    typedef struct packed {
        logic       wk, ov, rf;
        logic [1:0] rs, ts;
        logic       rq, ak, wf, we;
        logic [7:0] wd, ef, ee;
        logic       ei;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,4'd1},
        '{1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,8'h00,8'h80,8'h00,1'b0,4'd2},
        '{1'b0,1'b1,1'b1,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,8'h00,8'h83,8'h00,1'b0,4'd2},
        '{1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,8'h83,8'h83,8'h83,1'b1,4'd9},
        '{1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,8'h01,8'h82,8'h83,1'b1,4'd5},
        '{1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,8'h00,8'h82,8'h83,1'b1,4'd5},
        '{1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,8'h01,8'h83,8'h83,1'b1,4'd6},
        '{1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,1'b0,8'h00,8'hD3,8'h83,1'b1,4'd3},
        '{1'b0,1'b0,1'b0,2'b01,2'b10,1'b0,1'b0,1'b0,1'b0,8'h00,8'hDB,8'h83,1'b1,4'd3},
        '{1'b0,1'b0,1'b0,2'b01,2'b10,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h18,8'h83,1'b0,4'd4},
        '{1'b1,1'b0,1'b0,2'b01,2'b10,1'b1,1'b0,1'b0,1'b0,8'h00,8'h98,8'h83,1'b1,4'd8},
        '{1'b0,1'b0,1'b0,2'b01,2'b10,1'b1,1'b0,1'b1,1'b0,8'h80,8'h98,8'h83,1'b1,4'd8},
        '{1'b0,1'b0,1'b0,2'b01,2'b10,1'b1,1'b1,1'b0,1'b0,8'h00,8'h18,8'h83,1'b0,4'd7},
        '{1'b1,1'b0,1'b0,2'b10,2'b10,1'b1,1'b1,1'b0,1'b0,8'h00,8'h28,8'h83,1'b0,4'd7},
        '{1'b0,1'b0,1'b0,2'b10,2'b10,1'b0,1'b1,1'b0,1'b0,8'h00,8'h28,8'h83,1'b0,4'd7},
        '{1'b0,1'b1,1'b0,2'b10,2'b10,1'b0,1'b0,1'b0,1'b0,8'h00,8'h2A,8'h83,1'b1,4'd2},
        '{1'b0,1'b0,1'b0,2'b10,2'b10,1'b0,1'b0,1'b1,1'b0,8'h02,8'h28,8'h83,1'b0,4'd5},
        '{1'b0,1'b0,1'b0,2'b10,2'b10,1'b0,1'b0,1'b0,1'b1,8'hFF,8'h28,8'hC3,1'b0,4'd9}
    };

    function automatic string req_name(logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wake_evt = 0; ovr_evt = 0; rxfull_evt = 0;
        init_req = 0; init_ack = 0;
        cpu_wr_flag = 0; cpu_wr_en = 0; cpu_wdata = 8'h00;
    endtask

    // Drive at negedge, sample 2 ns after the following posedge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst_n = 0;
        rx_stat = 2'b00; tx_stat = 2'b00;
        idle_inputs();
        repeat (3) @(posedge clk);
        #2;
        check8("R1", "flags at reset", flag_rdata, 8'h00);
        check8("R1", "enable at reset", enable_rdata, 8'h00);
        check8("R1", "irq at reset", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wake_evt = VEC[i].wk; ovr_evt = VEC[i].ov; rxfull_evt = VEC[i].rf;
            rx_stat = VEC[i].rs; tx_stat = VEC[i].ts;
            init_req = VEC[i].rq; init_ack = VEC[i].ak;
            cpu_wr_flag = VEC[i].wf; cpu_wr_en = VEC[i].we; cpu_wdata = VEC[i].wd;
            step();
            check8(req_name(VEC[i].tag), $sformatf("vec %0d flags", i), flag_rdata, VEC[i].ef);
            check8(req_name(VEC[i].tag), $sformatf("vec %0d enable", i), enable_rdata, VEC[i].ee);
            check8("R10", $sformatf("vec %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].ei});
        end

        // R3 with enable: status-change raises irq
        @(negedge clk);
        idle_inputs();
        tx_stat = 2'b00;
        step();
        check8("R3", "status change flag", flag_rdata, 8'h60);
        check8("R10", "irq from status change", {7'd0, irq}, 8'h01);

        // R5: clear the status-change flag once levels are stable
        @(negedge clk);
        cpu_wr_flag = 1; cpu_wdata = 8'h40;
        step();
        check8("R5", "status change cleared", flag_rdata, 8'h20);
        check8("R10", "irq drops", {7'd0, irq}, 8'h00);

        // R1: mid-run reset clears everything including the status view
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        step();
        check8("R1", "flags after mid reset", flag_rdata, 8'h00);
        check8("R1", "enable after mid reset", enable_rdata, 8'h00);

        // R3: tracker restarts at 00, so the held level counts as a change
        @(negedge clk);
        rst_n = 1;
        step();
        check8("R3", "change after reset", flag_rdata, 8'h60);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule